// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps a record of the received packets that currently sit in a receive buffer and always presents a 16-bit status word for the oldest one. The MAC side announces the start of a packet, pulses once for every byte written into the buffer, and at the end of the packet supplies a 4-bit error code. The packet bytes are stored elsewhere. Only the byte counts and the number of queued packets are kept here.

The host side reads the status word and pulls bytes of the oldest packet one at a time. When it is done with that packet it issues a discard command. The block also raises diagnostic flags: one for a packet being received, one for a packet refused because the queue is full, and one for a read past the received bytes. It pulses an adapter-failure event when that read underrun first occurs, and pulses a completion event whenever a finished packet becomes the oldest entry.

Top module: `rx_status_queue`

## Requirements
- R1: With no packet queued, `status_word` reads 16'h8000: bit 15 set and all other bits zero.
- R2: While the oldest packet is still being received, `status_word` has bit 15 = 1, bits 14..11 = 0, and bits 10..0 = the number of bytes counted so far.
- R3: Once the oldest packet has ended, `status_word` has bit 15 = 0, bits 14..11 = the error code given at `mac_end`, and bits 10..0 = its byte count. Bit 14 is the top bit of the code, so it is 1 for error codes. A byte pulse in the same cycle as `mac_end` is counted.
- R4: A packet that receives more than MAX_LEN (1514) bytes is stored with length MAX_LEN and code 4'b1001 (oversize), whatever code comes with `mac_end`.
- R5: At most DEPTH (8) packets are held. A `mac_start` that finds DEPTH packets queued is refused, and that packet's bytes and end are ignored. The refusal sets `status_overrun`, which stays set until a discard removes a packet.
- R6: `host_discard` removes the oldest packet, and the next one becomes the top. A discard with an empty queue has no effect. Discarding a top packet that is still being received ends its reception.
- R7: `receiving` is 1 from the cycle after an accepted `mac_start` until the cycle after its `mac_end`.
- R8: A `host_read` with the queue empty, or after as many reads of the top packet as the bytes it has received, sets `rx_underrun`. This flag is sticky until `rx_reset` or `rst`. `adapter_fail` pulses for one cycle only when `rx_underrun` rises. A discard restarts the read count of the new top packet.
- R9: `rx_complete` pulses for one cycle after a finished packet becomes the top entry, either because it ended while on top or because a discard exposed it.
- R10: `rx_reset` (like `rst`) empties the queue and clears every flag and pulse in the next cycle. It takes priority over all other inputs.
- R11: A discard in the same cycle as a `mac_start` on a full queue frees the slot, so the new packet is accepted and `status_overrun` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_start | input | 1 | A new packet begins |
| mac_byte | input | 1 | One byte of the current packet was stored |
| mac_end | input | 1 | Current packet ends |
| mac_code | input | 4 | Error code of the ending packet |
| host_read | input | 1 | Host reads one byte of the top packet |
| host_discard | input | 1 | Host removes the top packet |
| rx_reset | input | 1 | Receive-side reset command |
| status_word | output | 16 | Status of the oldest packet |
| receiving | output | 1 | A packet is being received |
| status_overrun | output | 1 | A packet was refused because the queue is full |
| rx_underrun | output | 1 | Sticky read-past-end flag |
| adapter_fail | output | 1 | One-cycle failure event |
| rx_complete | output | 1 | One-cycle event: a finished packet is on top |

## Verification
The hardest overlap is a host discard in the same cycle as a MAC start on a full queue. The freed slot must be counted before the start is judged, or the packet would be refused wrongly. The bench fills the queue and then drives both inputs together. It expects reception to begin and the overrun flag to stay clear. Random traffic also makes a discard coincide with a packet end, which moves the top entry and fires the completion event. A reference model in the bench checks every output on every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_LEN_W  = 11;
  localparam int RXQ_CODE_W = 4;
  localparam logic [RXQ_CODE_W-1:0] RXQ_CODE_OVERSIZE = 4'b1001;
  localparam logic [15:0] RXQ_EMPTY_WORD = 16'h8000;

  typedef struct packed {
    logic [RXQ_CODE_W-1:0] code;
    logic [RXQ_LEN_W-1:0]  len;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_len_counter.sv
module rxq_len_counter #(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1514
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             byte_en,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] len_nxt,
  output logic             ovs_nxt
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);
  logic ovs_q;

  always_comb begin
    len_nxt = len_q;
    ovs_nxt = ovs_q;
    if (clr) begin
      len_nxt = '0;
      ovs_nxt = 1'b0;
    end else if (byte_en) begin
      if (len_q == CAP) ovs_nxt = 1'b1;
      else              len_nxt = len_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    len_q <= len_nxt;
    ovs_q <= ovs_nxt;
  end

  // R4: running count never exceeds the cap
  p_len_cap_r4: assert property (@(posedge clk) disable iff (clr) len_q <= CAP);
endmodule

// File: rtl/rxq_status_ram.sv
module rxq_status_ram #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  rxq_pkg::rxq_entry_t    wdata,
  input  logic [AW-1:0]          raddr,
  output rxq_pkg::rxq_entry_t    rdata
);
  rxq_pkg::rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_read_guard.sv
module rxq_read_guard #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             rd,
  input  logic             empty,
  input  logic [LEN_W-1:0] top_len,
  input  logic             discard,
  output logic             underrun_q,
  output logic             fail_q
);
  logic [LEN_W-1:0] rd_cnt;
  logic             over;

  assign over = rd && (empty || rd_cnt >= top_len);

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_cnt     <= '0;
      underrun_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      if (discard)        rd_cnt <= '0;
      else if (rd && !over) rd_cnt <= rd_cnt + 1'b1;
      if (over) underrun_q <= 1'b1;
      fail_q <= over && !underrun_q;
    end
  end

  // R8: the underrun flag only leaves through a clear
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (clr)
    underrun_q |=> underrun_q);
  // R8: a failure event always comes with the underrun flag
  p_fail_with_flag_r8: assert property (@(posedge clk) disable iff (clr)
    fail_q |-> underrun_q);
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue #(
  parameter int DEPTH   = 8,
  parameter int MAX_LEN = 1514
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mac_start,
  input  logic        mac_byte,
  input  logic        mac_end,
  input  logic [3:0]  mac_code,
  input  logic        host_read,
  input  logic        host_discard,
  input  logic        rx_reset,
  output logic [15:0] status_word,
  output logic        receiving,
  output logic        status_overrun,
  output logic        rx_underrun,
  output logic        adapter_fail,
  output logic        rx_complete
);
  import rxq_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] head_q, tail_q, wslot_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rcv_q, rcv_n, ovr_q, cmp_q;
  logic          clr, de, accept, wr_end, top_inprog, top_done_c, top_done_n;
  logic [RXQ_LEN_W-1:0] len_q, len_nxt, top_len;
  logic          ovs_nxt;
  rxq_entry_t    wdata, rdata;

  assign clr        = rst || rx_reset;
  assign de         = host_discard && (cnt_q != '0);
  assign accept     = mac_start && !rcv_q && ((cnt_q - CW'(de)) < FULL);
  assign wr_end     = rcv_q && mac_end;
  assign top_inprog = rcv_q && (cnt_q == CW'(1));
  assign top_done_c = (cnt_q != '0) && !top_inprog;

  always_comb begin
    rcv_n = rcv_q;
    if (wr_end || (de && top_inprog)) rcv_n = 1'b0;
    if (accept)                       rcv_n = 1'b1;
    cnt_n = cnt_q + CW'(accept) - CW'(de);
    top_done_n = (cnt_n != '0) && !(rcv_n && (cnt_n == CW'(1)));
  end

  rxq_len_counter #(.LEN_W(RXQ_LEN_W), .MAX_LEN(MAX_LEN)) u_len (
    .clk(clk), .clr(clr || accept), .byte_en(rcv_q && mac_byte),
    .len_q(len_q), .len_nxt(len_nxt), .ovs_nxt(ovs_nxt)
  );

  assign wdata.code = ovs_nxt ? RXQ_CODE_OVERSIZE : mac_code;
  assign wdata.len  = len_nxt;

  rxq_status_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_end && !clr), .waddr(wslot_q), .wdata(wdata),
    .raddr(head_q), .rdata(rdata)
  );

  assign top_len = top_inprog ? len_q : rdata.len;

  rxq_read_guard #(.LEN_W(RXQ_LEN_W)) u_guard (
    .clk(clk), .clr(clr), .rd(host_read), .empty(cnt_q == '0),
    .top_len(top_len), .discard(de), .underrun_q(rx_underrun), .fail_q(adapter_fail)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      head_q <= '0; tail_q <= '0; wslot_q <= '0; cnt_q <= '0;
      rcv_q <= 1'b0; ovr_q <= 1'b0; cmp_q <= 1'b0;
    end else begin
      if (de) head_q <= head_q + 1'b1;
      if (accept) begin
        wslot_q <= tail_q;
        tail_q  <= tail_q + 1'b1;
      end
      cnt_q <= cnt_n;
      rcv_q <= rcv_n;
      if (de) ovr_q <= 1'b0;
      else if (mac_start && !rcv_q && !accept) ovr_q <= 1'b1;
      cmp_q <= top_done_n && (de || !top_done_c);
    end
  end

  always_comb begin
    if (cnt_q == '0)     status_word = RXQ_EMPTY_WORD;
    else if (top_inprog) status_word = {1'b1, 4'b0000, len_q};
    else                 status_word = {1'b0, rdata.code, rdata.len};
  end

  assign receiving      = rcv_q;
  assign status_overrun = ovr_q;
  assign rx_complete    = cmp_q;

  // R5: occupancy bounded by the depth
  p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL);
  // R5: while refused-state holds, a start without discard is not accepted
  p_refuse_full_r5: assert property (@(posedge clk) disable iff (rst)
    (status_overrun && mac_start && !host_discard && !rx_reset) |=> !receiving);
  // R10: receive reset clears everything next cycle
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    rx_reset |=> (status_word == RXQ_EMPTY_WORD && !receiving && !status_overrun
                  && !rx_underrun && !rx_complete));
  // R9: a completion event shows a finished top packet
  p_complete_done_r9: assert property (@(posedge clk) disable iff (rst)
    rx_complete |-> !status_word[15]);
endmodule

// File: tb/tb_rx_status_queue.sv
module tb_rx_status_queue;
  localparam int MAXL = 1514;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st = 0, by = 0, en = 0, rd = 0, dc = 0, rr = 0;
  logic [3:0] ec = 0;
  logic [15:0] status_word;
  logic receiving, status_overrun, rx_underrun, adapter_fail, rx_complete;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_status_queue dut (
    .clk(clk), .rst(rst), .mac_start(st), .mac_byte(by), .mac_end(en),
    .mac_code(ec), .host_read(rd), .host_discard(dc), .rx_reset(rr),
    .status_word(status_word), .receiving(receiving), .status_overrun(status_overrun),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail), .rx_complete(rx_complete)
  );

  // reference model state
  int mcnt, mh, mt, mw, mcur, mrd;
  bit mrcv, movr, mund, movs, efail, ecmp;
  int mcode [8];
  int mlen [8];

  task automatic mreset();
    mcnt = 0; mh = 0; mt = 0; mw = 0; mcur = 0; mrd = 0;
    mrcv = 0; movr = 0; mund = 0; movs = 0; efail = 0; ecmp = 0;
  endtask

  task automatic model(bit s, bit b, bit e, int c, bit r, bit d, bit x);
    bit de, tdc, tdn, acc, nrcv, nov;
    int topl, ncur;
    if (x) begin mreset(); return; end
    de   = d && mcnt != 0;
    tdc  = mcnt != 0 && !(mrcv && mcnt == 1);
    topl = (mrcv && mcnt == 1) ? mcur : mlen[mh];
    efail = 0;
    if (r) begin
      if (mcnt == 0 || mrd >= topl) begin efail = !mund; mund = 1; end
      else mrd++;
    end
    if (de) mrd = 0;
    ncur = mcur; nov = movs;
    if (mrcv && b) begin
      if (mcur == MAXL) nov = 1; else ncur++;
    end
    acc = s && !mrcv && (mcnt - int'(de)) < 8;
    if (mrcv && e) begin mcode[mw] = nov ? 9 : c; mlen[mw] = ncur; end
    mcur = ncur; movs = nov;
    nrcv = mrcv;
    if ((mrcv && e) || (de && mrcv && mcnt == 1)) nrcv = 0;
    if (s && !mrcv && !acc) movr = 1;
    if (de) movr = 0;
    if (acc) begin mw = mt; mt = (mt + 1) % 8; nrcv = 1; mcur = 0; movs = 0; end
    if (de) mh = (mh + 1) % 8;
    mcnt = mcnt + int'(acc) - int'(de);
    mrcv = nrcv;
    tdn  = mcnt != 0 && !(mrcv && mcnt == 1);
    ecmp = tdn && (de || !tdc);
  endtask

  function automatic logic [15:0] exp_status();
    if (mcnt == 0) return 16'h8000;
    if (mrcv && mcnt == 1) return 16'h8000 | 16'(mcur);
    return {1'b0, 4'(mcode[mh]), 11'(mlen[mh])};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    t = (mcnt == 0) ? "R1 empty status" : ((mrcv && mcnt == 1) ? "R2 in-progress status" : "R3 done status");
    chk(t, status_word, exp_status());
    chk("R7 receiving", 16'(receiving), 16'(mrcv));
    chk("R5 status_overrun", 16'(status_overrun), 16'(movr));
    chk("R8 rx_underrun", 16'(rx_underrun), 16'(mund));
    chk("R8 adapter_fail", 16'(adapter_fail), 16'(efail));
    chk("R9 rx_complete", 16'(rx_complete), 16'(ecmp));
  endtask

  task automatic step(bit s, bit b, bit e, int c, bit r, bit d, bit x);
    st = s; by = b; en = e; ec = 4'(c); rd = r; dc = d; rr = x;
    model(s, b, e, c, r, d, x);
    @(posedge clk);
    @(negedge clk);
    st = 0; by = 0; en = 0; rd = 0; dc = 0; rr = 0;
    compare_all();
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'h1bad5eed);
    mreset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare_all();
    chk("R10 reset state", status_word, 16'h8000);

    // R2/R3/R7/R9 basic packet
    step(1, 0, 0, 0, 0, 0, 0);
    repeat (5) step(0, 1, 0, 0, 0, 0, 0);
    chk("R2 running count", status_word, 16'h8005);
    chk("R7 receiving high", 16'(receiving), 16'd1);
    step(0, 0, 1, 13, 0, 0, 0);
    chk("R3 finished status", status_word, 16'h6805);
    chk("R9 completion pulse", 16'(rx_complete), 16'd1);
    // R8 underrun after five good reads
    repeat (5) step(0, 0, 0, 0, 1, 0, 0);
    chk("R8 no underrun yet", 16'(rx_underrun), 16'd0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R8 underrun set", 16'(rx_underrun), 16'd1);
    chk("R8 fail pulse", 16'(adapter_fail), 16'd1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R10 underrun cleared", 16'(rx_underrun), 16'd0);
    chk("R10 queue empty", status_word, 16'h8000);

    // R4 oversize
    step(1, 0, 0, 0, 0, 0, 0);
    repeat (1520) step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R4 oversize status", status_word, 16'h4DEA);

    // R6 discard and empty discard
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 discard empties", status_word, 16'h8000);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 empty discard ignored", status_word, 16'h8000);

    // R5 fill, refuse, R11 discard+start
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, i, 0, 0, 0);
    end
    chk("R5 oldest entry kept", status_word, 16'h0000);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R5 overrun set", 16'(status_overrun), 16'd1);
    chk("R5 refused not receiving", 16'(receiving), 16'd0);
    step(0, 1, 1, 5, 0, 0, 0);
    chk("R5 refused end ignored", status_word, 16'h0000);
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R11 accepted with discard", 16'(receiving), 16'd1);
    chk("R11 overrun clear", 16'(status_overrun), 16'd0);
    chk("R6 next top shown", status_word, 16'h0800);
    step(0, 0, 0, 0, 0, 0, 1);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      step($urandom % 6 == 0, $urandom % 2 == 0, $urandom % 12 == 0, int'($urandom % 16),
           $urandom % 7 == 0, $urandom % 9 == 0, $urandom % 700 == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule